// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. The model has a registered read path with one pipeline stage and a short internal burst counter. Accesses begin when one of two address strobes is sampled low on a rising clock edge. One strobe is intended for a processor and is gated by the primary select. The other is intended for a memory controller and is always honoured. Each strobe loads a base address. After that, every edge with the advance input low steps the burst to the next word. When advance is high, the burst stays on its current word. Only the low burst bits of the address count; they wrap after four beats, so the base word returns.

Three select inputs decide whether a strobe starts an access or ends one. A strobe with any select inactive is a deselect cycle, and the read outputs go quiet one edge later. Writes use either a global write input or a byte-write input together with per-lane enables. The data bus is split into a data input, a data output and an output-valid flag. The flag stands for the driven (low-impedance) state of the pins, and the output enable gates it. The full part is 128K words of 32 bits (`ADDR_W` = 17); the default address width is smaller for simulation.

Top module: `psb_sram`

## Requirements
- R1: The part counts as selected only when `sel_n` = 0, `sel2_n` = 0 and `sel_hi` = 1, all sampled on the strobe edge. An accepted strobe edge with any of the three inactive ends the current burst.
- R2: A read access whose address register is loaded on edge k presents that word on `dout` with `dout_valid` = 1 after edge k+1. Before edge k+1, the output does not yet show that word.
- R3: On an edge with no accepted strobe, a live burst and `advance_n` = 0, the low `BURST_W` address bits increment modulo 2^`BURST_W` in linear order. The upper bits stay fixed.
- R4: On an edge with no accepted strobe, a live burst and `advance_n` = 1, the burst address holds. The same word is therefore presented again.
- R5: With `BURST_W` = 2, four advances bring the burst back to its base word, which is then output again.
- R6: A strobe accepted while a burst is live loads the new base address, and the burst continues from that address.
- R7: After a deselect edge, `dout_valid` is 0 from the following edge on.
- R8: A low `proc_strobe_n` has no effect while `sel_n` = 1. A low `ctrl_strobe_n` is always accepted.
- R9: `wr_all_n` = 0 writes all lanes. Otherwise `wr_byte_n` = 0 writes each lane i whose `lane_n[i]` = 0, and lane i is `din[8i+7:8i]`. Writes land on the address that the same edge selects: the loaded base, the next burst word, or the held word.
- R10: An access loaded by the processor strobe is always a read: the write inputs on that edge are ignored. If both strobes are low, the processor strobe wins.
- R11: `out_en_n` = 1 forces `dout_valid` to 0 without changing the registered read data. Write cycles produce no valid output.
- R12: During and right after reset, no burst is live and `dout_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address, loaded by a strobe |
| proc_strobe_n | input | 1 | Processor address strobe, active low, gated by `sel_n` |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low; high suspends |
| sel_n | input | 1 | Primary select, active low |
| sel2_n | input | 1 | Second select, active low |
| sel_hi | input | 1 | Third select, active high |
| out_en_n | input | 1 | Output enable, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Per-lane write qualifier, active low |
| lane_n | input | LANES | Per-lane write enables, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_valid | output | 1 | Output driven (low-impedance) |

## Verification
Every word is first written with a distinct, address-derived pattern. Then a burst is started at every base address, using the pattern advance, advance, suspend, advance, advance, advance, followed by a deselect. This separates linear stepping from other orders, shows suspension as one repeated word, shows the wrap back to the base at every starting offset, and shows that the outputs go quiet exactly one edge after the deselect. Targeted sequences cover the other cases:
- mid-burst reloads;
- a processor strobe with the primary select high, where a wrongly accepted load would change the word that follows;
- writes on a processor strobe, which must leave memory unchanged;
- partial lane masks and burst writes, checked by reading the words back;
- the output enable, which must hide data that is still held in the register.

// File: rtl/psb_pkg.sv
package psb_pkg;
   // Action taken by the burst controller on a clock edge
   typedef enum logic [1:0] {
      STEP_IDLE = 2'd0,
      STEP_LOAD = 2'd1,
      STEP_NEXT = 2'd2,
      STEP_HOLD = 2'd3
   } psb_step_e;
endpackage

// File: rtl/psb_ctrl.sv
module psb_ctrl
   import psb_pkg::*;
#(
   parameter int AW    = 8,
   parameter int BW    = 2,
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr,
   input  logic             proc_n,
   input  logic             ctrl_n,
   input  logic             adv_n,
   input  logic             sel_n,
   input  logic             sel2_n,
   input  logic             sel_hi,
   input  logic             wr_all_n,
   input  logic             wr_byte_n,
   input  logic [LANES-1:0] lane_n,
   output logic [AW-1:0]    burst_addr,
   output logic             burst_live,
   output logic             burst_rd,
   output logic [AW-1:0]    wr_addr,
   output logic [LANES-1:0] wr_lanes
);
   localparam int HI_W = AW - BW;

   psb_step_e        step;
   logic             proc_take;
   logic             take;
   logic             chosen;
   logic             wr_ok;
   logic             live_nxt;
   logic [AW-1:0]    addr_nxt;
   logic [AW-1:0]    addr_inc;
   logic [LANES-1:0] lane_req;

   assign proc_take = !proc_n && !sel_n;
   assign take      = proc_take || !ctrl_n;
   assign chosen    = !sel_n && !sel2_n && sel_hi;

   // Linear burst step: only the low BW bits count, the rest stay fixed
   assign addr_inc = {burst_addr[AW-1 -: HI_W], burst_addr[BW-1:0] + 1'b1};

   always_comb begin
      if (!wr_all_n)       lane_req = '1;
      else if (!wr_byte_n) lane_req = ~lane_n;
      else                 lane_req = '0;
   end

   always_comb begin
      if (take)            step = STEP_LOAD;
      else if (!burst_live) step = STEP_IDLE;
      else if (adv_n)      step = STEP_HOLD;
      else                 step = STEP_NEXT;
   end

   always_comb begin
      addr_nxt = burst_addr;
      live_nxt = burst_live;
      wr_ok    = 1'b0;
      unique case (step)
         STEP_LOAD: begin
            addr_nxt = addr;
            live_nxt = chosen;
            wr_ok    = chosen && !proc_take;
         end
         STEP_NEXT: begin
            addr_nxt = addr_inc;
            wr_ok    = 1'b1;
         end
         STEP_HOLD: begin
            wr_ok    = 1'b1;
         end
         default: begin
            live_nxt = 1'b0;
         end
      endcase
   end

   assign wr_addr  = addr_nxt;
   assign wr_lanes = wr_ok ? lane_req : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         burst_addr <= '0;
         burst_live <= 1'b0;
         burst_rd   <= 1'b0;
      end else begin
         burst_addr <= addr_nxt;
         burst_live <= live_nxt;
         burst_rd   <= live_nxt && (wr_lanes == '0);
      end
   end
endmodule

// File: rtl/psb_lane.sv
module psb_lane #(
   parameter int AW = 8,
   parameter int LW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [LW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [LW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [LW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/psb_rdpipe.sv
module psb_rdpipe #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_go,
   input  logic [DW-1:0] rd_word,
   output logic [DW-1:0] q_data,
   output logic          q_valid
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_data  <= '0;
         q_valid <= 1'b0;
      end else begin
         q_valid <= rd_go;
         if (rd_go) q_data <= rd_word;
      end
   end
endmodule

// File: rtl/psb_sram.sv
module psb_sram #(
   parameter int ADDR_W  = 8,
   parameter int BURST_W = 2,
   parameter int LANES   = 4,
   parameter int LANE_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         addr,
   input  logic                      proc_strobe_n,
   input  logic                      ctrl_strobe_n,
   input  logic                      advance_n,
   input  logic                      sel_n,
   input  logic                      sel2_n,
   input  logic                      sel_hi,
   input  logic                      out_en_n,
   input  logic                      wr_all_n,
   input  logic                      wr_byte_n,
   input  logic [LANES-1:0]          lane_n,
   input  logic [LANES*LANE_W-1:0]   din,
   output logic [LANES*LANE_W-1:0]   dout,
   output logic                      dout_valid
);
   localparam int DATA_W = LANES * LANE_W;

   if (BURST_W < 1 || BURST_W >= ADDR_W) begin : g_bad_burst
      $error("psb_sram: BURST_W must be at least 1 and below ADDR_W");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("psb_sram: LANES and LANE_W must be positive");
   end

   logic [ADDR_W-1:0] burst_addr;
   logic              burst_live;
   logic              burst_rd;
   logic [ADDR_W-1:0] wr_addr;
   logic [LANES-1:0]  wr_lanes;
   logic [DATA_W-1:0] rd_word;
   logic [DATA_W-1:0] q_data;
   logic              q_valid;

   psb_ctrl #(
      .AW    (ADDR_W),
      .BW    (BURST_W),
      .LANES (LANES)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (addr),
      .proc_n     (proc_strobe_n),
      .ctrl_n     (ctrl_strobe_n),
      .adv_n      (advance_n),
      .sel_n      (sel_n),
      .sel2_n     (sel2_n),
      .sel_hi     (sel_hi),
      .wr_all_n   (wr_all_n),
      .wr_byte_n  (wr_byte_n),
      .lane_n     (lane_n),
      .burst_addr (burst_addr),
      .burst_live (burst_live),
      .burst_rd   (burst_rd),
      .wr_addr    (wr_addr),
      .wr_lanes   (wr_lanes)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      psb_lane #(
         .AW (ADDR_W),
         .LW (LANE_W)
      ) u_lane (
         .clk   (clk),
         .we    (wr_lanes[i]),
         .waddr (wr_addr),
         .wdata (din[i*LANE_W +: LANE_W]),
         .raddr (burst_addr),
         .rdata (rd_word[i*LANE_W +: LANE_W])
      );
   end

   psb_rdpipe #(
      .DW (DATA_W)
   ) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_go   (burst_rd),
      .rd_word (rd_word),
      .q_data  (q_data),
      .q_valid (q_valid)
   );

   assign dout       = q_data;
   assign dout_valid = q_valid && !out_en_n;
endmodule

// File: rtl/psb_sram_chk.sv
module psb_sram_chk #(
   parameter int AW = 8,
   parameter int BW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] addr,
   input logic          proc_strobe_n,
   input logic          ctrl_strobe_n,
   input logic          advance_n,
   input logic          sel_n,
   input logic          sel2_n,
   input logic          sel_hi,
   input logic [AW-1:0] burst_addr,
   input logic          burst_live,
   input logic          q_valid,
   input logic          dout_valid
);
   logic take;
   logic chosen;
   assign take   = (!proc_strobe_n && !sel_n) || !ctrl_strobe_n;
   assign chosen = !sel_n && !sel2_n && sel_hi;

   // R6 accepted strobe loads a new base
   a_r6_new_base: assert property (@(posedge clk) disable iff (!rst_n)
      (take && chosen) |=> (burst_live && burst_addr == $past(addr)));

   // R1 strobe with an inactive select ends the burst
   a_r1_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !chosen) |=> !burst_live);

   // R3 linear step of the low bits, upper bits fixed
   a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && burst_live && !advance_n) |=>
         (burst_addr[AW-1:BW] == $past(burst_addr[AW-1:BW]) &&
          burst_addr[BW-1:0] == BW'($past(burst_addr[BW-1:0]) + 1'b1)));

   // R4 suspension holds the burst address
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && burst_live && advance_n) |=> ($stable(burst_addr) && burst_live));

   // R7 outputs quiet one edge after a deselect edge
   a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !chosen) |=> ##1 !dout_valid);

   // R8 processor strobe is ignored while the primary select is high
   a_r8_proc_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_strobe_n && sel_n && ctrl_strobe_n && !burst_live) |=> !burst_live);

   // R10 processor-strobe load is a read, visible two edges later
   a_r10_proc_reads: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_strobe_n && chosen) |=> ##1 q_valid);

   // R2 valid data only follows a live access
   a_r2_lag: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q_valid) |-> $past(burst_live));
endmodule

bind psb_sram psb_sram_chk #(
   .AW (ADDR_W),
   .BW (BURST_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .addr          (addr),
   .proc_strobe_n (proc_strobe_n),
   .ctrl_strobe_n (ctrl_strobe_n),
   .advance_n     (advance_n),
   .sel_n         (sel_n),
   .sel2_n        (sel2_n),
   .sel_hi        (sel_hi),
   .burst_addr    (burst_addr),
   .burst_live    (burst_live),
   .q_valid       (q_valid),
   .dout_valid    (dout_valid)
);

// File: tb/psb_sram_bench.sv
`timescale 1ns/1ps
module psb_sram_bench;
   localparam int AW = 8;
   localparam int N  = 1 << AW;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [AW-1:0] addr;
   logic        proc_strobe_n, ctrl_strobe_n, advance_n;
   logic        sel_n, sel2_n, sel_hi, out_en_n;
   logic        wr_all_n, wr_byte_n;
   logic [3:0]  lane_n;
   logic [31:0] din;
   logic [31:0] dout;
   logic        dout_valid;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_mem [N];

   always #5 clk = ~clk;

   psb_sram u_psb_sram (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
      .advance_n(advance_n), .sel_n(sel_n), .sel2_n(sel2_n), .sel_hi(sel_hi),
      .out_en_n(out_en_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
      .lane_n(lane_n), .din(din), .dout(dout), .dout_valid(dout_valid)
   );

   function automatic logic [31:0] pat(input int a);
      return {8'(a), ~8'(a), 8'(a) ^ 8'h5A, 8'(a + 51)};
   endfunction

   function automatic int wrap(input int b, input int j);
      return (b & ~3) | ((b + j) & 3);
   endfunction

   task automatic idle();
      proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; advance_n = 1'b1;
      sel_n = 1'b0; sel2_n = 1'b0; sel_hi = 1'b1; out_en_n = 1'b0;
      wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_n = 4'hF; din = '0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_rd(input string tag, input logic [31:0] exp);
      checks++;
      if (dout_valid !== 1'b1 || dout !== exp) begin
         errors++;
         $display("FAIL %s: valid=%0b dout=%h expected valid=1 dout=%h",
                  tag, dout_valid, dout, exp);
      end
   endtask

   task automatic check_off(input string tag);
      checks++;
      if (dout_valid !== 1'b0) begin
         errors++;
         $display("FAIL %s: valid=%0b expected valid=0", tag, dout_valid);
      end
   endtask

   task automatic deselect();
      idle(); ctrl_strobe_n = 1'b0; sel2_n = 1'b1; tick();
      idle(); tick();
   endtask

   // Load with the processor strobe, hold one edge, check the word
   task automatic read1(input string tag, input int a);
      idle(); proc_strobe_n = 1'b0; addr = AW'(a); tick();
      idle(); tick();
      check_rd(tag, exp_mem[a]);
      deselect();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R0 watchdog expired: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle(); addr = '0; rst_n = 1'b0;
      repeat (3) tick();
      check_off("R12 in reset");
      rst_n = 1'b1; tick();
      check_off("R12 after reset");

      // Fill: controller strobe with global write, one word per edge (R9)
      for (int a = 0; a < N; a++) begin
         idle(); ctrl_strobe_n = 1'b0; addr = AW'(a); wr_all_n = 1'b0;
         din = pat(a); exp_mem[a] = pat(a); tick();
         check_off("R11 write cycle no output");
      end
      deselect();

      // Burst sweep over every base
      for (int b = 0; b < N; b++) begin
         idle(); proc_strobe_n = 1'b0; addr = AW'(b); tick();
         check_off("R2 not before next edge");
         idle(); advance_n = 1'b0; tick();
         check_rd("R2 base word", exp_mem[b]);
         idle(); advance_n = 1'b0; tick();
         check_rd("R3 linear step", exp_mem[wrap(b, 1)]);
         idle(); tick();
         check_rd("R3 second step", exp_mem[wrap(b, 2)]);
         idle(); advance_n = 1'b0; tick();
         check_rd("R4 suspended repeat", exp_mem[wrap(b, 2)]);
         idle(); advance_n = 1'b0; tick();
         check_rd("R3 third step", exp_mem[wrap(b, 3)]);
         idle(); advance_n = 1'b0; tick();
         check_rd("R5 wrap to base", exp_mem[b]);
         idle(); ctrl_strobe_n = 1'b0; sel2_n = 1'b1; tick();
         check_rd("R7 tail word at deselect", exp_mem[wrap(b, 1)]);
         idle(); tick();
         check_off("R7 quiet after deselect");
      end

      // R6 mid-burst reload
      idle(); proc_strobe_n = 1'b0; addr = 8'd60; tick();
      idle(); advance_n = 1'b0; tick();
      check_rd("R6 first burst", exp_mem[60]);
      idle(); proc_strobe_n = 1'b0; addr = 8'd200; tick();
      check_rd("R6 old burst step", exp_mem[61]);
      idle(); advance_n = 1'b0; tick();
      check_rd("R6 new base", exp_mem[200]);
      idle(); advance_n = 1'b0; tick();
      check_rd("R6 continues from new base", exp_mem[201]);
      deselect();

      // R8 processor strobe ignored with sel_n high
      idle(); ctrl_strobe_n = 1'b0; addr = 8'd8; tick();
      idle(); proc_strobe_n = 1'b0; sel_n = 1'b1; addr = 8'd100; tick();
      check_rd("R8 controller read", exp_mem[8]);
      idle(); tick();
      check_rd("R8 gated strobe ignored", exp_mem[8]);
      // R8 controller strobe accepted even with sel_n high (deselects)
      idle(); ctrl_strobe_n = 1'b0; sel_n = 1'b1; tick();
      idle(); tick();
      check_off("R8 controller strobe always taken");

      // R1 inactive third select on a processor strobe deselects
      idle(); proc_strobe_n = 1'b0; addr = 8'd9; tick();
      idle(); proc_strobe_n = 1'b0; sel_hi = 1'b0; tick();
      check_rd("R1 live before", exp_mem[9]);
      idle(); tick();
      check_off("R1 sel_hi low ends access");

      // R10 processor strobe ignores write inputs
      idle(); proc_strobe_n = 1'b0; addr = 8'd70; wr_all_n = 1'b0;
      din = 32'h0BAD_F00D; tick();
      idle(); tick();
      check_rd("R10 read despite write inputs", exp_mem[70]);
      deselect();
      read1("R10 memory untouched", 70);

      // R9 lane writes: lanes 0 and 2
      idle(); ctrl_strobe_n = 1'b0; addr = 8'd20; wr_byte_n = 1'b0;
      lane_n = 4'b1010; din = 32'hDEAD_BEEF; tick();
      exp_mem[20] = (exp_mem[20] & 32'hFF00_FF00) | (32'hDEAD_BEEF & 32'h00FF_00FF);
      deselect();
      read1("R9 lanes 0 and 2", 20);
      // wr_byte_n high: lane enables ignored, no write
      idle(); ctrl_strobe_n = 1'b0; addr = 8'd21; lane_n = 4'b0000;
      din = 32'h1234_5678; tick();
      deselect();
      read1("R9 no write without qualifier", 21);

      // R9 burst write: base, next word, next word lane 3 only
      idle(); ctrl_strobe_n = 1'b0; addr = 8'd40; wr_all_n = 1'b0;
      din = 32'hA0A0_0001; tick();
      exp_mem[40] = 32'hA0A0_0001;
      idle(); advance_n = 1'b0; wr_all_n = 1'b0; din = 32'hA0A0_0002; tick();
      exp_mem[41] = 32'hA0A0_0002;
      check_off("R11 burst write no output");
      idle(); advance_n = 1'b0; wr_byte_n = 1'b0; lane_n = 4'b0111;
      din = 32'hC3C3_C3C3; tick();
      exp_mem[42] = (exp_mem[42] & 32'h00FF_FFFF) | 32'hC300_0000;
      deselect();
      read1("R9 burst base", 40);
      read1("R9 burst second", 41);
      read1("R9 burst lane 3", 42);

      // R11 output enable hides held data
      idle(); proc_strobe_n = 1'b0; addr = 8'd5; tick();
      idle(); out_en_n = 1'b1; tick();
      check_off("R11 out_en_n high");
      out_en_n = 1'b0; #1;
      check_rd("R11 data held under disable", exp_mem[5]);
      deselect();

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule